// File: doc/BRIEF.md
# Watchdog and Display Tick Source Selector

This block turns one system clock into two streams of single-cycle clock-enable strobes. One stream paces a watchdog timer and the other paces a display controller. It generates no derived or gated clocks. Every consumer runs on the system clock and qualifies its logic with the strobe.

Two time bases feed the strobes. The first is a free-running binary prescaler, with one tap for each consumer. The second is an 8-bit modulus down-counter that reloads from a writable value whenever it passes zero. Its underflow goes through small post-dividers, a divide-by-4 for the watchdog and a divide-by-8 for the display.

A static PLL-mode input chooses between the two time bases for each consumer. The display has its own select bit that sends the raw modulus underflow straight to it. Both outputs are registered, so a change of selection applies from the next source pulse onward.

Top module: `tick_select_gen`

## Requirements
- R1: `rst_n` asserts asynchronously and clears the prescaler, the modulus counter, the post-dividers and both outputs. While `rst_n` is low both outputs are 0. Internal reset is released on the second rising clock edge after `rst_n` rises. With `pll_mode_i`=0, the first watchdog strobe is high in cycle 2^WDT_TAP+2 after `rst_n` rises. With `dsp_sel_i`=0, the first display strobe is high in cycle 3.
- R2: With `pll_mode_i`=0, the watchdog strobe repeats every 2^WDT_TAP clock cycles (the prescaler tap).
- R3: With `pll_mode_i`=1, the watchdog strobe repeats every 4*(R+1) cycles, where R is the programmed reload value.
- R4: With `dsp_sel_i`=0, the display strobe repeats every R+1 cycles, whatever the value of `pll_mode_i`.
- R5: With `dsp_sel_i`=1 and `pll_mode_i`=1, the display strobe repeats every 8*(R+1) cycles.
- R6: With `dsp_sel_i`=1 and `pll_mode_i`=0, the display strobe repeats every 2^DSP_TAP cycles (the prescaler tap).
- R7: When `reload_we_i` is high at a clock edge, `reload_val_i` is stored. The count in progress is not disturbed, and the stored value is loaded at the next underflow. The reload value after reset is 255.
- R8: Every strobe is exactly one cycle wide. The one exception is the display strobe with `dsp_sel_i`=0 and R=0, which is high in every cycle.
- R9: Each output is registered one cycle after its selected source. After a select change, the strobes that follow are spaced by the period of the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_mode_i | input | 1 | Time base select: 0 prescaler taps, 1 modulus timer |
| dsp_sel_i | input | 1 | Display select: 0 raw modulus underflow, 1 mode-dependent path |
| reload_we_i | input | 1 | Write strobe for the modulus reload value |
| reload_val_i | input | MOD_W | New modulus reload value |
| wdt_tick_o | output | 1 | Watchdog clock-enable strobe |
| dsp_tick_o | output | 1 | Display clock-enable strobe |

## Verification
The raw display path is swept over every reload value from 0 to 31, and over 255, under both PLL modes. This shows that the modulus period is R+1 and that PLL mode has no effect on that path. The divided paths are tried with several reload values, which separates a divide-by-4 or divide-by-8 from an off-by-one in the divider or in the reload. The prescaler paths use short bench taps to pin down the exact tap period, and a reset-release sequence fixes the latency of each path. A reload written in mid-count must leave the current period intact and take hold only on the following one. A display select switch must be followed at once by the new spacing.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [1:0] {
    SRC_PRESCALE = 2'd0,
    SRC_MODULUS  = 2'd1,
    SRC_MOD_DIV  = 2'd2
  } tick_src_e;

  function automatic tick_src_e wdt_source(input logic pll_mode);
    return pll_mode ? SRC_MOD_DIV : SRC_PRESCALE;
  endfunction

  function automatic tick_src_e dsp_source(input logic pll_mode, input logic dsp_sel);
    if (!dsp_sel) return SRC_MODULUS;
    return pll_mode ? SRC_MOD_DIV : SRC_PRESCALE;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int TAP_A = 15,
  parameter int TAP_B = 14
) (
  input  logic clk,
  input  logic rst_ni,
  output logic tap_a_o,
  output logic tap_b_o
);
  localparam int PRE_W = (TAP_A > TAP_B) ? TAP_A : TAP_B;
  localparam logic [PRE_W-1:0] ONE = {{(PRE_W-1){1'b0}}, 1'b1};

  logic [PRE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_comb begin
    tap_a_o = &cnt_q[TAP_A-1:0];
    tap_b_o = &cnt_q[TAP_B-1:0];
  end

  initial begin
    if (TAP_A < 1 || TAP_B < 1) $error("prescaler taps must be at least 1");
  end

  // R2: a prescaler tap never fires in two adjacent cycles
  p_tap_a_single_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    tap_a_o |=> !tap_a_o);
  // R6
  p_tap_b_single_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    tap_b_o |=> !tap_b_o);
endmodule

// File: rtl/tick_modulus.sv
module tick_modulus #(
  parameter int MOD_W = 8,
  parameter logic [MOD_W-1:0] RELOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             reload_we_i,
  input  logic [MOD_W-1:0] reload_val_i,
  output logic             uf_o
);
  localparam logic [MOD_W-1:0] ONE = {{(MOD_W-1){1'b0}}, 1'b1};

  logic [MOD_W-1:0] cnt_q, cnt_d;
  logic [MOD_W-1:0] rel_q, rel_d;
  logic             at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    cnt_d   = at_zero ? rel_q : (cnt_q - ONE);
    rel_d   = reload_we_i ? reload_val_i : rel_q;
    uf_o    = at_zero;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= RELOAD_RST;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  // R7: an underflow loads the reload value held at that edge
  p_reload_at_uf_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    at_zero |=> (cnt_q == $past(rel_q)));
  // R7: a write never alters the running count away from an underflow
  p_write_keeps_count_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (reload_we_i && !at_zero) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/tick_postdiv.sv
module tick_postdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic src_i,
  output logic tick_o
);
  generate
    if (DIV > 1) begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

      logic [CW-1:0] cnt_q, cnt_d;
      logic          at_last;

      always_comb begin
        at_last = (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (src_i) cnt_d = at_last ? '0 : (cnt_q + ONE);
        tick_o  = src_i && at_last;
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end

      // R3/R5: an output pulse restarts the source count
      p_restart_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_ni)
        tick_o |=> (cnt_q == '0));
      // R5: the count only moves on a source pulse
      p_hold_without_src_r5: assert property (@(posedge clk) disable iff (!rst_ni)
        !src_i |=> (cnt_q == $past(cnt_q)));
    end else begin : g_thru
      always_comb tick_o = src_i;
    end
  endgenerate
endmodule

// File: rtl/tick_route.sv
module tick_route
  import tick_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic pll_mode_i,
  input  logic dsp_sel_i,
  input  logic pre_wdt_i,
  input  logic pre_dsp_i,
  input  logic mod_uf_i,
  input  logic div_wdt_i,
  input  logic div_dsp_i,
  output logic wdt_tick_o,
  output logic dsp_tick_o
);
  tick_src_e wdt_src, dsp_src;
  logic      wdt_d, dsp_d;
  logic      wdt_q, dsp_q;

  always_comb begin
    wdt_src = wdt_source(pll_mode_i);
    dsp_src = dsp_source(pll_mode_i, dsp_sel_i);
    unique case (wdt_src)
      SRC_MOD_DIV: wdt_d = div_wdt_i;
      default:     wdt_d = pre_wdt_i;
    endcase
    unique case (dsp_src)
      SRC_MODULUS: dsp_d = mod_uf_i;
      SRC_MOD_DIV: dsp_d = div_dsp_i;
      default:     dsp_d = pre_dsp_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_q <= 1'b0;
      dsp_q <= 1'b0;
    end else begin
      wdt_q <= wdt_d;
      dsp_q <= dsp_d;
    end
  end

  assign wdt_tick_o = wdt_q;
  assign dsp_tick_o = dsp_q;

  // R8: the watchdog strobe is always a single cycle
  p_wdt_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    wdt_q |=> !wdt_q);
  // R8: divided and prescaled display strobes are single-cycle
  p_dsp_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (dsp_q && dsp_sel_i && $past(dsp_sel_i)) |=> (!dsp_q || !dsp_sel_i));
  // R9: a watchdog strobe is preceded by a pulse of one of its sources
  p_wdt_has_source_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(wdt_q) |-> $past(pre_wdt_i || div_wdt_i));
endmodule

// File: rtl/tick_select_gen.sv
module tick_select_gen #(
  parameter int MOD_W      = 8,
  parameter int WDT_TAP    = 15,
  parameter int DSP_TAP    = 14,
  parameter int WDT_DIV    = 4,
  parameter int DSP_DIV    = 8,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_mode_i,
  input  logic             dsp_sel_i,
  input  logic             reload_we_i,
  input  logic [MOD_W-1:0] reload_val_i,
  output logic             wdt_tick_o,
  output logic             dsp_tick_o
);
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_ni;

  generate
    if (RST_STAGES > 1) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end
  endgenerate

  assign rst_ni = rst_sync_q[RST_STAGES-1];

  logic pre_wdt, pre_dsp, mod_uf, div_wdt, div_dsp;

  tick_prescaler #(.TAP_A(WDT_TAP), .TAP_B(DSP_TAP)) u_pre (
    .clk(clk), .rst_ni(rst_ni), .tap_a_o(pre_wdt), .tap_b_o(pre_dsp)
  );

  tick_modulus #(.MOD_W(MOD_W)) u_mod (
    .clk(clk), .rst_ni(rst_ni), .reload_we_i(reload_we_i),
    .reload_val_i(reload_val_i), .uf_o(mod_uf)
  );

  tick_postdiv #(.DIV(WDT_DIV)) u_div_wdt (
    .clk(clk), .rst_ni(rst_ni), .src_i(mod_uf), .tick_o(div_wdt)
  );

  tick_postdiv #(.DIV(DSP_DIV)) u_div_dsp (
    .clk(clk), .rst_ni(rst_ni), .src_i(mod_uf), .tick_o(div_dsp)
  );

  tick_route u_route (
    .clk(clk), .rst_ni(rst_ni), .pll_mode_i(pll_mode_i), .dsp_sel_i(dsp_sel_i),
    .pre_wdt_i(pre_wdt), .pre_dsp_i(pre_dsp), .mod_uf_i(mod_uf),
    .div_wdt_i(div_wdt), .div_dsp_i(div_dsp),
    .wdt_tick_o(wdt_tick_o), .dsp_tick_o(dsp_tick_o)
  );

  // R1: outputs are quiet while the internal reset is held
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!wdt_tick_o && !dsp_tick_o));
endmodule

// File: tb/tick_select_gen_test.sv
module tick_select_gen_test;
  localparam int WT = 6;
  localparam int DT = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pll_mode = 1'b0;
  logic       dsp_sel = 1'b0;
  logic       rel_we = 1'b0;
  logic [7:0] rel_val = 8'd0;
  logic       wdt_tick, dsp_tick;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tick_select_gen #(.WDT_TAP(WT), .DSP_TAP(DT)) uut (
    .clk(clk), .rst_n(rst_n), .pll_mode_i(pll_mode), .dsp_sel_i(dsp_sel),
    .reload_we_i(rel_we), .reload_val_i(rel_val),
    .wdt_tick_o(wdt_tick), .dsp_tick_o(dsp_tick)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic tick(input bit pick_dsp);
    return pick_dsp ? dsp_tick : wdt_tick;
  endfunction

  task automatic measure(input bit pick_dsp, output int per, output int wid);
    int g = 0;
    per = 0; wid = 0;
    while (tick(pick_dsp) && g < 20000) begin @(negedge clk); g++; end
    while (!tick(pick_dsp) && g < 20000) begin @(negedge clk); g++; end
    while (tick(pick_dsp) && g < 20000) begin @(negedge clk); g++; wid++; end
    per = wid;
    while (!tick(pick_dsp) && g < 20000) begin @(negedge clk); g++; per++; end
    if (g >= 20000) per = -1;
  endtask

  task automatic set_reload(input int v);
    @(negedge clk);
    rel_we = 1'b1; rel_val = 8'(v);
    @(negedge clk);
    rel_we = 1'b0;
  endtask

  task automatic expect_period(input bit pick_dsp, input int exp, input string tag);
    int p, w;
    measure(pick_dsp, p, w);
    measure(pick_dsp, p, w);
    measure(pick_dsp, p, w);
    check(p == exp, tag, p, exp);
    check(w == 1, "R8 width", w, 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, p, w;
    repeat (3) @(negedge clk);
    // R1: outputs low while reset is held
    check(!wdt_tick && !dsp_tick, "R1 reset outputs", {wdt_tick, dsp_tick}, 0);

    // R1: first-strobe latency from reset release
    rst_n = 1'b1;
    n = 0;
    while (!dsp_tick && n < 1000) begin @(negedge clk); n++; end
    check(n == 3, "R1 first display strobe", n, 3);
    do_reset();
    rst_n = 1'b1;
    n = 0;
    while (!wdt_tick && n < 1000) begin @(negedge clk); n++; end
    check(n == (1 << WT) + 2, "R1 first watchdog strobe", n, (1 << WT) + 2);

    // R2 / R6: prescaler paths
    pll_mode = 1'b0; dsp_sel = 1'b0;
    expect_period(1'b0, 1 << WT, "R2 watchdog prescaler period");
    dsp_sel = 1'b1;
    expect_period(1'b1, 1 << DT, "R6 display prescaler period");

    // R7: reload value after reset gives period 256 on the raw path
    dsp_sel = 1'b0;
    expect_period(1'b1, 256, "R7 reset reload value");

    // R8: R=0 on raw display path is high in every cycle
    set_reload(0);
    repeat (300) @(negedge clk);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      if (dsp_tick) n++;
      @(negedge clk);
    end
    check(n == 10, "R8 display continuous at R=0", n, 10);

    // R4: raw path sweep under both modes
    for (int m = 0; m < 2; m++) begin
      pll_mode = m[0];
      for (int r = 1; r < 32; r++) begin
        set_reload(r);
        expect_period(1'b1, r + 1, "R4 raw display period");
      end
    end
    set_reload(255);
    expect_period(1'b1, 256, "R4 raw display period R=255");

    // R3 / R5: divided modulus paths
    pll_mode = 1'b1;
    for (int k = 0; k < 5; k++) begin
      int r;
      r = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 7 : 31;
      set_reload(r);
      dsp_sel = 1'b0;
      expect_period(1'b0, 4 * (r + 1), "R3 watchdog divided period");
      dsp_sel = 1'b1;
      expect_period(1'b1, 8 * (r + 1), "R5 display divided period");
    end

    // R7: write during a count leaves the current period intact
    dsp_sel = 1'b0;
    set_reload(20);
    measure(1'b1, p, w);
    measure(1'b1, p, w);
    rel_we = 1'b1; rel_val = 8'd5;
    @(negedge clk);
    rel_we = 1'b0;
    n = 1;
    while (!dsp_tick && n < 1000) begin @(negedge clk); n++; end
    check(n == 21, "R7 period in progress keeps old reload", n, 21);
    measure(1'b1, p, w);
    check(p == 6, "R7 new reload on next period", p, 6);

    // R9: select switch applies new spacing at once
    set_reload(3);
    pll_mode = 1'b1; dsp_sel = 1'b0;
    measure(1'b1, p, w);
    measure(1'b1, p, w);
    check(p == 4, "R9 before switch", p, 4);
    dsp_sel = 1'b1;
    measure(1'b1, p, w);
    check(p == 32, "R9 after switch", p, 32);
    pll_mode = 1'b0;
    measure(1'b1, p, w);
    measure(1'b1, p, w);
    check(p == (1 << DT), "R9 after mode change", p, 1 << DT);

    // R1: mid-run reset restores latency
    do_reset();
    check(!wdt_tick && !dsp_tick, "R1 mid-run reset outputs", {wdt_tick, dsp_tick}, 0);
    dsp_sel = 1'b0;
    rst_n = 1'b1;
    n = 0;
    while (!wdt_tick && n < 1000) begin @(negedge clk); n++; end
    check(n == (1 << WT) + 2, "R1 watchdog latency after mid-run reset", n, (1 << WT) + 2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule